// File: doc/BRIEF.md
# Adaptive Decision-Feedback Equalizer with LMS Tap Adaptation

This block cleans up inter-symbol interference on a serial link that delivers one signed fixed-point sample per bit. For every accepted sample it subtracts a feedback term from the sample. The feedback term is built from the four most recent bit decisions, each weighted by its own tap. The block slices the result to a symbol of +1 or -1 and reports the decision one clock later. In the same clock edge it nudges every tap along the least-mean-squares gradient. The error that drives this nudge is the equalized value minus a reference symbol.

The reference symbol has two sources. In training mode it is a known bit supplied from outside. In blind mode it is the slicer's own decision. When no decisions are wrong, both modes steer the taps to the same place. A three-bit step code sets the adaptation gain. A larger code converges faster but leaves more tap jitter at steady state. Code zero stops adaptation. A freeze input holds the taps while equalization continues. A synchronous clear returns the block to its start state.

Samples and taps are 16-bit signed values with 13 fraction bits, so the value 8192 stands for 1.0.

Top module: `lms_dfe_engine`

## Requirements
- R1: After reset or a clear, all four taps read 0, `dec_vld` is 0, and the decision history holds +1 in every position.
- R2: For a sample accepted in cycle n, `dec_vld` is 1 in cycle n+1 only. `dec_bit` gives the sign of y = sample − Σ c_k·d_k, where `dec_bit` = 1 means +1 and 0 means −1. A value of y = 0 decides +1.
- R3: Tap k (k = 1..4) is weighted by the k-th most recent decision and appears on `taps_flat[16k-1:16k-16]`. The history shifts on every accepted sample, including frozen ones.
- R4: With `train_mode` = 1, the error is e = y − (train_bit ? 8192 : −8192).
- R5: With `train_mode` = 0, the error is e = y − (new decision ? 8192 : −8192).
- R6: Each accepted, unfrozen sample updates every tap as c_k += (d_k = +1 ? Δ : −Δ), with Δ = floor(e·5·step_code / 2048).
- R7: With `step_code` = 0, the taps do not change, while decisions continue.
- R8: With `freeze` = 1, the taps hold, while decisions and the history still advance.
- R9: A tap update that would leave the range saturates to 32767 or −32768 and never wraps.
- R10: A clear in the same cycle as a valid sample wins: the sample is dropped, no decision is reported, and the R1 state results.
- R11: In a cycle with `smp_vld` = 0, the taps, the history and the decision output stay unchanged, and `dec_vld` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of taps and history |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 16 | Signed Q2.13 received sample |
| train_mode | input | 1 | 1 = error from reference bit, 0 = decision-directed |
| train_bit | input | 1 | Known reference bit (1 = +1) |
| step_code | input | 3 | Adaptation gain code, step ≈ code × 0.00244 |
| freeze | input | 1 | Hold taps, keep equalizing |
| dec_vld | output | 1 | Decision valid, one cycle after the sample |
| dec_bit | output | 1 | Decided symbol (1 = +1) |
| taps_flat | output | 64 | Four signed Q2.13 taps, most recent decision's tap lowest |

## Verification
A clear can arrive in the same cycle as a valid sample. This collision is forced in the middle of a trained stream, on a cycle where the taps are far from zero. The bench expects no decision pulse, all-zero taps, and a following sample that is equalized and updated from a +1 history. A freeze can also overlap a run of valid samples. This case is judged on a later unfrozen sample: its decision and update come out right only if the history kept shifting while the taps stood still.

// File: rtl/lms_dfe_pkg.sv
package lms_dfe_pkg;

  // Source of the reference symbol that the error is measured against
  typedef enum logic {
    ERR_FROM_DECISION  = 1'b0,
    ERR_FROM_REFERENCE = 1'b1
  } err_src_e;

  // Step mantissa is (1 << STEP_MANT_SHIFT) + 1 = 5, applied as shift-add
  localparam int STEP_MANT_SHIFT = 2;

endpackage

// File: rtl/dfe_history.sv
module dfe_history #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic [N-1:0] hist
);

  logic [N-1:0] hist_q;
  logic [N-1:0] hist_nxt;

  for (genvar k = 0; k < N; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign hist_nxt[k] = din;
    end else begin : g_tail
      assign hist_nxt[k] = hist_q[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hist_q <= '1;
    end else if (shift_en) begin
      hist_q <= hist_nxt;
    end
  end

  assign hist = hist_q;

endmodule

// File: rtl/dfe_slicer.sv
module dfe_slicer
  import lms_dfe_pkg::*;
#(
  parameter int W     = 16,
  parameter int FRAC  = 13,
  parameter int N     = 4,
  parameter int ACC_W = W + $clog2(N) + 1,
  parameter int ERR_W = ACC_W + 1
) (
  input  logic signed [W-1:0]     sample,
  input  logic        [N*W-1:0]   taps_flat,
  input  logic        [N-1:0]     hist,
  input  err_src_e                src,
  input  logic                    train_bit,
  output logic                    dec,
  output logic signed [ERR_W-1:0] err
);

  localparam logic signed [ERR_W-1:0] ONE_Q = ERR_W'(2**FRAC);

  logic signed [ACC_W-1:0] term [N];
  logic signed [ACC_W-1:0] fb;
  logic signed [ACC_W-1:0] y;
  logic                    ref_sym;

  // Each tap contributes +c or -c depending on its stored decision
  for (genvar k = 0; k < N; k++) begin : g_term
    logic signed [ACC_W-1:0] tap_ext;
    assign tap_ext = ACC_W'($signed(taps_flat[k*W +: W]));
    assign term[k] = hist[k] ? tap_ext : -tap_ext;
  end

  always_comb begin
    fb = '0;
    for (int k = 0; k < N; k++) begin
      fb = fb + term[k];
    end
  end

  assign y       = ACC_W'(sample) - fb;
  assign dec     = ~y[ACC_W-1];
  assign ref_sym = (src == ERR_FROM_REFERENCE) ? train_bit : dec;
  assign err     = ERR_W'(y) - (ref_sym ? ONE_Q : -ONE_Q);

endmodule

// File: rtl/dfe_tap_bank.sv
module dfe_tap_bank
  import lms_dfe_pkg::*;
#(
  parameter int W        = 16,
  parameter int N        = 4,
  parameter int ERR_W    = 20,
  parameter int MU_W     = 3,
  parameter int MU_SHIFT = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    upd_en,
  input  logic signed [ERR_W-1:0] err,
  input  logic        [MU_W-1:0]  step_code,
  input  logic        [N-1:0]     hist,
  output logic        [N*W-1:0]   taps_flat
);

  localparam int PROD_W = ERR_W + STEP_MANT_SHIFT + 1 + MU_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [SUM_W-1:0] TAP_MAX = SUM_W'({1'b0, {(W-1){1'b1}}});
  localparam logic signed [SUM_W-1:0] TAP_MIN = ~TAP_MAX;

  logic signed [PROD_W-1:0] e_ext;
  logic signed [PROD_W-1:0] e_mant;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] step;
  logic signed [W-1:0]      tap_q   [N];
  logic signed [W-1:0]      tap_nxt [N];

  // step = floor(err * 5 * code / 2^MU_SHIFT), built from shifts and adds
  assign e_ext  = PROD_W'(err);
  assign e_mant = (e_ext <<< STEP_MANT_SHIFT) + e_ext;

  always_comb begin
    prod = '0;
    for (int b = 0; b < MU_W; b++) begin
      if (step_code[b]) begin
        prod = prod + (e_mant <<< b);
      end
    end
  end

  assign step = prod >>> MU_SHIFT;

  for (genvar k = 0; k < N; k++) begin : g_tap
    logic signed [SUM_W-1:0] cand;
    assign cand = SUM_W'(tap_q[k]) + (hist[k] ? SUM_W'(step) : -SUM_W'(step));

    always_comb begin
      if (cand > TAP_MAX) begin
        tap_nxt[k] = {1'b0, {(W-1){1'b1}}};
      end else if (cand < TAP_MIN) begin
        tap_nxt[k] = {1'b1, {(W-1){1'b0}}};
      end else begin
        tap_nxt[k] = cand[W-1:0];
      end
    end

    assign taps_flat[k*W +: W] = tap_q[k];
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < N; k++) begin
      if (rst || clr) begin
        tap_q[k] <= '0;
      end else if (upd_en) begin
        tap_q[k] <= tap_nxt[k];
      end
    end
  end

endmodule

// File: rtl/lms_dfe_engine.sv
module lms_dfe_engine
  import lms_dfe_pkg::*;
#(
  parameter int W        = 16,
  parameter int FRAC     = 13,
  parameter int NTAPS    = 4,
  parameter int MU_W     = 3,
  parameter int MU_SHIFT = 11
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   smp_vld,
  input  logic signed [W-1:0]    smp_data,
  input  logic                   train_mode,
  input  logic                   train_bit,
  input  logic [MU_W-1:0]        step_code,
  input  logic                   freeze,
  output logic                   dec_vld,
  output logic                   dec_bit,
  output logic [NTAPS*W-1:0]     taps_flat
);

  localparam int ACC_W = W + $clog2(NTAPS) + 1;
  localparam int ERR_W = ACC_W + 1;

  err_src_e                src;
  logic                    fire;
  logic                    dec;
  logic signed [ERR_W-1:0] err;
  logic [NTAPS-1:0]        hist;
  logic [NTAPS*W-1:0]      taps_cur;

  assign src  = err_src_e'(train_mode);
  assign fire = smp_vld & ~clr;

  dfe_history #(.N(NTAPS)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .shift_en (fire),
    .din      (dec),
    .hist     (hist)
  );

  dfe_slicer #(
    .W(W), .FRAC(FRAC), .N(NTAPS), .ACC_W(ACC_W), .ERR_W(ERR_W)
  ) u_slice (
    .sample    (smp_data),
    .taps_flat (taps_cur),
    .hist      (hist),
    .src       (src),
    .train_bit (train_bit),
    .dec       (dec),
    .err       (err)
  );

  dfe_tap_bank #(
    .W(W), .N(NTAPS), .ERR_W(ERR_W), .MU_W(MU_W), .MU_SHIFT(MU_SHIFT)
  ) u_taps (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .upd_en    (fire & ~freeze),
    .err       (err),
    .step_code (step_code),
    .hist      (hist),
    .taps_flat (taps_cur)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      dec_vld <= 1'b0;
      dec_bit <= 1'b1;
    end else begin
      dec_vld <= fire;
      if (fire) begin
        dec_bit <= dec;
      end
    end
  end

  assign taps_flat = taps_cur;

endmodule

// File: rtl/lms_dfe_chk.sv
module lms_dfe_chk #(
  parameter int W     = 16,
  parameter int NTAPS = 4,
  parameter int MU_W  = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               clr,
  input logic               smp_vld,
  input logic               freeze,
  input logic [MU_W-1:0]    step_code,
  input logic               dec_vld,
  input logic [NTAPS*W-1:0] taps_flat
);

  // R1 R10
  clear_state_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (taps_flat == '0) && !dec_vld);

  // R2
  dec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !clr) |=> dec_vld);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!smp_vld && !clr) |=> (!dec_vld && $stable(taps_flat)));

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (freeze && !clr) |=> $stable(taps_flat));

  // R7
  zero_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((step_code == '0) && !clr) |=> $stable(taps_flat));

  for (genvar k = 0; k < NTAPS; k++) begin : g_wrap
    // R9
    pos_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      ((taps_flat[k*W+W-1 -: 2] == 2'b01) && !clr) |=> !taps_flat[k*W+W-1]);
    // R9
    neg_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      ((taps_flat[k*W+W-1 -: 2] == 2'b10) && !clr) |=> taps_flat[k*W+W-1]);
  end

endmodule

bind lms_dfe_engine lms_dfe_chk #(.W(W), .NTAPS(NTAPS), .MU_W(MU_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr       (clr),
  .smp_vld   (smp_vld),
  .freeze    (freeze),
  .step_code (step_code),
  .dec_vld   (dec_vld),
  .taps_flat (taps_flat)
);

// File: tb/lms_dfe_engine_tb.sv
module lms_dfe_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 16;
  localparam int MUW = 3;

  logic clk = 1'b0;
  logic rst, clr;
  logic smp_vld, train_mode, train_bit, freeze;
  logic signed [W-1:0] smp_data;
  logic [MUW-1:0] step_code;
  logic dec_vld, dec_bit;
  logic [4*W-1:0] taps_flat;

  logic s_vld, s_bit;
  logic signed [W-1:0] s_data;
  logic s_dvld, s_dbit;
  logic [W-1:0] s_taps;

  always #(CLK_PERIOD/2) clk = ~clk;

  lms_dfe_engine u_dut (
    .clk(clk), .rst(rst), .clr(clr), .smp_vld(smp_vld), .smp_data(smp_data),
    .train_mode(train_mode), .train_bit(train_bit), .step_code(step_code),
    .freeze(freeze), .dec_vld(dec_vld), .dec_bit(dec_bit), .taps_flat(taps_flat)
  );

  // single-tap copy used to reach the tap limit
  lms_dfe_engine #(.NTAPS(1)) u_sat (
    .clk(clk), .rst(rst), .clr(clr), .smp_vld(s_vld), .smp_data(s_data),
    .train_mode(1'b1), .train_bit(s_bit), .step_code(3'd7),
    .freeze(1'b0), .dec_vld(s_dvld), .dec_bit(s_dbit), .taps_flat(s_taps)
  );

  int n_vec = 0;
  int n_err = 0;
  int mt [2][4];
  bit mh [2][4];
  int ntap [2] = '{4, 1};
  bit [8:0] lfsr = 9'h1ff;
  bit ch [4] = '{1'b1, 1'b1, 1'b1, 1'b1};

  task automatic check(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void mdl_clear(input int i);
    for (int k = 0; k < 4; k++) begin
      mt[i][k] = 0;
      mh[i][k] = 1'b1;
    end
  endfunction

  function automatic int sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic bit mdl_step(input int i, input int x, input bit train, input bit rb,
                                  input int mu, input bit frz);
    longint fb = 0;
    longint y, e, p, d;
    bit dec, r;
    for (int k = 0; k < ntap[i]; k++) fb += mh[i][k] ? mt[i][k] : -mt[i][k];
    y   = x - fb;
    dec = (y >= 0);
    r   = train ? rb : dec;
    e   = y - (r ? 8192 : -8192);
    p   = e * 5 * mu;
    d   = p >>> 11;
    if (!frz)
      for (int k = 0; k < ntap[i]; k++)
        mt[i][k] = sat16(mt[i][k] + (mh[i][k] ? d : -d));
    for (int k = 3; k > 0; k--) mh[i][k] = mh[i][k-1];
    mh[i][0] = dec;
    return dec;
  endfunction

  function automatic int sym(input bit b);
    return b ? 8192 : -8192;
  endfunction

  // channel with post-cursor interference driven by a 9-bit PRBS
  task automatic chan_next(output int x, output bit b);
    bit nb;
    nb = lfsr[8] ^ lfsr[4];
    lfsr = {lfsr[7:0], nb};
    for (int k = 3; k > 0; k--) ch[k] = ch[k-1];
    ch[0] = nb;
    x = sym(ch[0]) + sym(ch[1]) / 2 + sym(ch[2]) / 4 - sym(ch[3]) / 8;
    b = nb;
  endtask

  task automatic cyc(input bit vld, input int x, input bit train, input bit rb,
                     input int mu, input bit frz, input bit c, input string req);
    bit ev = 1'b0;
    bit ed = 1'b0;
    smp_vld = vld; smp_data = x[W-1:0]; train_mode = train; train_bit = rb;
    step_code = mu[MUW-1:0]; freeze = frz; clr = c; s_vld = 1'b0;
    if (c) begin
      mdl_clear(0);
      mdl_clear(1);
    end else if (vld) begin
      ed = mdl_step(0, x, train, rb, mu, frz);
      ev = 1'b1;
    end
    @(negedge clk);
    check(req, "dec_vld", int'(dec_vld), int'(ev));
    if (ev) check(req, "dec_bit", int'(dec_bit), int'(ed));
    for (int k = 0; k < 4; k++)
      check(req, $sformatf("tap%0d", k + 1), int'($signed(taps_flat[k*W +: W])), mt[0][k]);
  endtask

  task automatic t_reset();
    rst = 1'b1; clr = 1'b0; smp_vld = 1'b0; smp_data = '0; train_mode = 1'b1;
    train_bit = 1'b0; step_code = '0; freeze = 1'b0; s_vld = 1'b0; s_data = '0; s_bit = 1'b0;
    mdl_clear(0);
    mdl_clear(1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", "dec_vld", int'(dec_vld), 0);
    for (int k = 0; k < 4; k++)
      check("R1", "tap", int'($signed(taps_flat[k*W +: W])), 0);
    check("R1", "sat tap", int'($signed(s_taps)), 0);
    // first decision uses +1 history in every slot (R1, R3)
    cyc(1'b1, 1000, 1'b1, 1'b1, 4, 1'b0, 1'b0, "R1");
  endtask

  task automatic t_train();
    int x; bit b;
    cyc(1'b0, 0, 1'b1, 1'b0, 0, 1'b0, 1'b1, "R1");
    for (int n = 0; n < 300; n++) begin
      chan_next(x, b);
      cyc(1'b1, x, 1'b1, b, 4, 1'b0, 1'b0, "R2/R3/R4/R6");
    end
  endtask

  task automatic t_blind();
    int x; bit b;
    for (int n = 0; n < 300; n++) begin
      chan_next(x, b);
      cyc(1'b1, x, 1'b0, ~b, 2, 1'b0, 1'b0, "R5");
    end
  endtask

  task automatic t_zero_step();
    int x; bit b;
    for (int n = 0; n < 40; n++) begin
      chan_next(x, b);
      cyc(1'b1, x, 1'b1, ~b, 0, 1'b0, 1'b0, "R7");
    end
  endtask

  task automatic t_freeze();
    int x; bit b;
    for (int n = 0; n < 40; n++) begin
      chan_next(x, b);
      cyc(1'b1, x, 1'b1, ~b, 5, 1'b1, 1'b0, "R8");
    end
    for (int n = 0; n < 20; n++) begin
      chan_next(x, b);
      cyc(1'b1, x, 1'b1, b, 3, 1'b0, 1'b0, "R8");
    end
  endtask

  task automatic t_gaps();
    int x; bit b;
    for (int n = 0; n < 40; n++) begin
      chan_next(x, b);
      cyc(1'b0, -x, 1'b1, ~b, 7, 1'b0, 1'b0, "R11");
      cyc(1'b1, x, 1'b1, b, 1, 1'b0, 1'b0, "R11");
    end
  endtask

  task automatic t_clear_collide();
    int x; bit b;
    for (int n = 0; n < 30; n++) begin
      chan_next(x, b);
      cyc(1'b1, x, 1'b1, b, 6, 1'b0, 1'b0, "R10");
    end
    chan_next(x, b);
    cyc(1'b1, x, 1'b1, b, 6, 1'b0, 1'b1, "R10");
    for (int n = 0; n < 10; n++) begin
      chan_next(x, b);
      cyc(1'b1, -x, 1'b1, ~b, 6, 1'b0, 1'b0, "R10");
    end
  endtask

  task automatic t_saturate();
    bit ed;
    int x;
    bit rb;
    smp_vld = 1'b0; clr = 1'b0;
    for (int n = 0; n < 300; n++) begin
      x  = mh[1][0] ? 32767 : -32768;
      rb = ~mh[1][0];
      s_vld = 1'b1; s_data = x[W-1:0]; s_bit = rb;
      ed = mdl_step(1, x, 1'b1, rb, 7, 1'b0);
      @(negedge clk);
      check("R9", "sat dec_vld", int'(s_dvld), 1);
      check("R9", "sat dec_bit", int'(s_dbit), int'(ed));
      check("R9", "sat tap", int'($signed(s_taps)), mt[1][0]);
    end
    s_vld = 1'b0;
    check("R9", "tap at upper limit", int'($signed(s_taps)), 32767);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (all R): actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_train();
    t_blind();
    t_zero_step();
    t_freeze();
    t_gaps();
    t_clear_collide();
    t_saturate();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule